// File: doc/BRIEF.md
# Two-Lane Panel Link Transmit Sequencer

This block is the transmit-side sequencer for a point-to-point display link that has only two lanes: one clock lane and one data lane. It runs at the serial bit rate and drives one bit on each lane per cycle. Every subpixel travels as a 10-bit symbol. The clock lane therefore carries one waveform period per symbol, which is one tenth of the data bit rate. Frame timing and control information are carried inside vertical blanking on these same two lanes, so the link needs no separate sync or control wires.

A pulse on `frame_start` opens a blanking interval. First the clock lane carries a distinct sync shape for four symbols. Then the data lane sends a programmable number of alignment preamble symbols, which let the receiver find subpixel boundaries. Then it sends a programmable number of command words taken from a command register bank. After that, the block streams pixels, one subpixel symbol at a time in R, G, B order, until the next `frame_start`. If the pixel source runs dry at a pixel boundary, the last symbol is repeated and a sticky flag is raised.

Top module: `panel_link_seq`

## Requirements
- R1: After synchronous reset and until the first `frame_start`, `data_lane`, `clk_lane`, `pix_take` and `underflow` are all 0. The `frame_start` pulse starts the first sync symbol on the next cycle.
- R2: Each symbol occupies exactly 10 consecutive cycles. Bits leave MSB first: bit 9 of the word goes out in the first cycle.
- R3: Outside the sync phase, the clock lane carries the shape 1111100000 for every symbol (high for 5 cycles, then low for 5).
- R4: Each blanking interval begins with exactly 4 sync symbols. During these the clock lane carries 1110001110 and the data lane is 0.
- R5: After the sync symbols, the data lane sends `cfg_pre_len` preamble symbols of value 1111100000. A count of 0 skips this phase.
- R6: After the preamble, the data lane sends N command words, where N is `cfg_cmd_cnt` clamped to CMD_MAX (4). Word i is `cmd_words[10*i+9 : 10*i]`, sent in ascending i. N = 0 skips this phase.
- R7: In active video, each pixel is sent as three symbols: R = `pix_data[29:20]`, then G = `pix_data[19:10]`, then B = `pix_data[9:0]`. `pix_take` pulses for one cycle in the last cycle of the preceding symbol, when the pixel is captured.
- R8: If `pix_valid` is low when a new pixel is due, the previous symbol is sent again and `underflow` rises and stays 1 until reset. The pixel is tried again at the next symbol boundary.
- R9: A `frame_start` pulse during active video lets the current symbol finish, and the next symbol is the first sync symbol. This holds even when the pulse comes in the middle of a pixel.
- R10: A `frame_start` pulse during the sync, preamble or command phases is ignored, and the blanking sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | Pulse that requests a new frame |
| pix_valid | input | 1 | Pixel source has a pixel ready |
| pix_data | input | 30 | Pixel as R, G and B 10-bit words (R in the top bits) |
| cmd_words | input | 40 | Command register bank, word i at bits 10*i+9 to 10*i |
| cfg_pre_len | input | 8 | Number of preamble symbols per blanking interval |
| cfg_cmd_cnt | input | 3 | Requested number of command words |
| data_lane | output | 1 | Serial data lane bit |
| clk_lane | output | 1 | Clock lane bit |
| pix_take | output | 1 | Pixel captured at this edge |
| underflow | output | 1 | Sticky pixel-starvation flag |

## Verification
A wrong phase counter makes whole symbols appear or vanish: a sync, preamble or command run comes out one symbol too long or too short. That shift is visible on the lanes within 10 cycles of the faulty boundary, and every later symbol in the frame then arrives misaligned. A wrong bit index or a bad word selection corrupts the bit pattern inside a symbol right away. A bad R/G/B pointer swaps subpixels within the first pixel. Starvation handling that is wrong shows up as a symbol other than the repeated one, or as an `underflow` flag that clears. The bench compares every symbol of every frame against words it computes itself, across a sweep of preamble and command counts.

// File: rtl/link_seq_pkg.sv
package link_seq_pkg;

  localparam int SYM_W = 10;
  localparam int IDX_W = $clog2(SYM_W);

  localparam logic [SYM_W-1:0] CLK_SHAPE  = 10'b1111100000;
  localparam logic [SYM_W-1:0] SYNC_SHAPE = 10'b1110001110;
  localparam logic [SYM_W-1:0] ALIGN_WORD = 10'b1111100000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_VSYNC,
    ST_PREAMBLE,
    ST_COMMAND,
    ST_ACTIVE
  } seq_state_e;

  // Bit of a symbol word on the wire at position idx, MSB first.
  function automatic logic lane_bit(input logic [SYM_W-1:0] w,
                                    input logic [IDX_W-1:0] idx);
    return w[SYM_W-1-int'(idx)];
  endfunction

  // Requested count limited to the number of available slots.
  function automatic int clamp_count(input int req, input int lim);
    return (req > lim) ? lim : req;
  endfunction

endpackage

// File: rtl/link_seq_serdes.sv
module link_seq_serdes
  import link_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [SYM_W-1:0] nxt_data,
  input  logic [SYM_W-1:0] nxt_clk,
  output logic             data_lane,
  output logic             clk_lane,
  output logic             sym_last,
  output logic [SYM_W-1:0] cur_data,
  output logic [IDX_W-1:0] bit_idx
);

  logic [SYM_W-1:0] cur_clk;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_idx  <= '0;
      cur_data <= '0;
      cur_clk  <= '0;
    end else if (load) begin
      bit_idx  <= '0;
      cur_data <= nxt_data;
      cur_clk  <= nxt_clk;
    end else if (run) begin
      bit_idx  <= bit_idx + 1'b1;
    end
  end

  assign sym_last  = (bit_idx == IDX_W'(SYM_W - 1));
  assign data_lane = lane_bit(cur_data, bit_idx);
  assign clk_lane  = lane_bit(cur_clk, bit_idx);

  // R2: bit position never leaves the symbol
  p_bit_range_r2: assert property (@(posedge clk) disable iff (rst)
    bit_idx < IDX_W'(SYM_W));

  // R2: a symbol word is held until its last bit has gone out
  p_word_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (run && !load) |=> $stable(cur_data));

endmodule

// File: rtl/link_seq_ctrl.sv
module link_seq_ctrl
  import link_seq_pkg::*;
#(
  parameter int SYNC_SYMS = 4,
  parameter int CNT_W     = 8,
  parameter int CMD_MAX   = 4,
  parameter int CMD_REQ_W = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frame_start,
  input  logic                 sym_last,
  input  logic [CNT_W-1:0]     cfg_pre_len,
  input  logic [CMD_REQ_W-1:0] cfg_cmd_cnt,
  output seq_state_e           state,
  output seq_state_e           nxt_state,
  output logic [CNT_W-1:0]     nxt_cnt,
  output logic                 load
);

  logic [CNT_W-1:0]     cnt;
  logic                 pending;
  logic [CMD_REQ_W-1:0] cmd_n;
  logic                 restart;
  seq_state_e           after_sync;
  seq_state_e           after_pre;

  assign cmd_n   = CMD_REQ_W'(clamp_count(int'(cfg_cmd_cnt), CMD_MAX));
  assign load    = (state == ST_IDLE) ? frame_start : sym_last;
  assign restart = (state == ST_IDLE) ||
                   ((state == ST_ACTIVE) && (pending || frame_start));

  always_comb begin
    after_pre  = (cmd_n != '0) ? ST_COMMAND : ST_ACTIVE;
    after_sync = (cfg_pre_len != '0) ? ST_PREAMBLE : after_pre;
  end

  always_comb begin
    nxt_state = state;
    nxt_cnt   = cnt;
    if (load) begin
      if (restart) begin
        nxt_state = ST_VSYNC;
        nxt_cnt   = '0;
      end else begin
        case (state)
          ST_VSYNC: begin
            if (cnt == CNT_W'(SYNC_SYMS - 1)) begin
              nxt_state = after_sync;
              nxt_cnt   = '0;
            end else begin
              nxt_cnt = cnt + 1'b1;
            end
          end
          ST_PREAMBLE: begin
            if ((cnt + 1'b1) == cfg_pre_len) begin
              nxt_state = after_pre;
              nxt_cnt   = '0;
            end else begin
              nxt_cnt = cnt + 1'b1;
            end
          end
          ST_COMMAND: begin
            if ((cnt + 1'b1) == CNT_W'(cmd_n)) begin
              nxt_state = ST_ACTIVE;
              nxt_cnt   = '0;
            end else begin
              nxt_cnt = cnt + 1'b1;
            end
          end
          default: nxt_cnt = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      pending <= 1'b0;
    end else begin
      state   <= nxt_state;
      cnt     <= nxt_cnt;
      pending <= load ? 1'b0 : (pending || ((state == ST_ACTIVE) && frame_start));
    end
  end

  // R4: sync phase never runs past its symbol count
  p_sync_len_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_VSYNC) |-> (cnt < CNT_W'(SYNC_SYMS)));

  // R9, R10: a sync phase is entered only from idle or active video
  p_sync_entry_r10: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_VSYNC) && ($past(state) != ST_VSYNC)) |->
      (($past(state) == ST_IDLE) || ($past(state) == ST_ACTIVE)));

  // R6: command phase stays within the clamped count
  p_cmd_len_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_COMMAND) |-> (cnt < CNT_W'(CMD_MAX)));

endmodule

// File: rtl/link_seq_words.sv
module link_seq_words
  import link_seq_pkg::*;
#(
  parameter int CMD_MAX = 4,
  parameter int CNT_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  seq_state_e               state,
  input  seq_state_e               nxt_state,
  input  logic [CNT_W-1:0]         nxt_cnt,
  input  logic                     pix_valid,
  input  logic [3*SYM_W-1:0]       pix_data,
  input  logic [CMD_MAX*SYM_W-1:0] cmd_words,
  input  logic [SYM_W-1:0]         cur_data,
  output logic [SYM_W-1:0]         nxt_data,
  output logic [SYM_W-1:0]         nxt_clk,
  output logic                     pix_take,
  output logic                     underflow
);

  localparam int CI_W = (CMD_MAX > 1) ? $clog2(CMD_MAX) : 1;

  logic [SYM_W-1:0]   cmd_arr [CMD_MAX];
  logic [SYM_W-1:0]   cmd_sel;
  logic [3*SYM_W-1:0] pix_q;
  logic [1:0]         rgb;
  logic               want_pixel;
  logic               starve;
  logic               enter_active;

  for (genvar g = 0; g < CMD_MAX; g++) begin : g_cmd
    assign cmd_arr[g] = cmd_words[g*SYM_W +: SYM_W];
  end

  assign cmd_sel = (nxt_cnt < CNT_W'(CMD_MAX)) ? cmd_arr[nxt_cnt[CI_W-1:0]] : '0;

  assign enter_active = load && (nxt_state == ST_ACTIVE);
  assign want_pixel   = enter_active && (rgb == 2'd0);
  assign pix_take     = want_pixel && pix_valid;
  assign starve       = want_pixel && !pix_valid;

  always_comb begin
    nxt_clk = (nxt_state == ST_VSYNC) ? SYNC_SHAPE : CLK_SHAPE;
    case (nxt_state)
      ST_PREAMBLE: nxt_data = ALIGN_WORD;
      ST_COMMAND:  nxt_data = cmd_sel;
      ST_ACTIVE: begin
        case (rgb)
          2'd0:    nxt_data = pix_valid ? pix_data[3*SYM_W-1 -: SYM_W] : cur_data;
          2'd1:    nxt_data = pix_q[2*SYM_W-1 -: SYM_W];
          default: nxt_data = pix_q[SYM_W-1:0];
        endcase
      end
      default:     nxt_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rgb       <= 2'd0;
      pix_q     <= '0;
      underflow <= 1'b0;
    end else begin
      underflow <= underflow || starve;
      if (load && (nxt_state == ST_VSYNC)) begin
        rgb <= 2'd0;
      end else if (enter_active) begin
        if (rgb == 2'd0) begin
          if (pix_valid) begin
            pix_q <= pix_data;
            rgb   <= 2'd1;
          end
        end else begin
          rgb <= (rgb == 2'd2) ? 2'd0 : rgb + 2'd1;
        end
      end
    end
  end

  // R8: starvation flag is sticky
  p_underflow_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    underflow |=> underflow);

  // R7: a captured pixel's red word is the next symbol on the wire
  p_take_red_r7: assert property (@(posedge clk) disable iff (rst)
    pix_take |=> ((state == ST_ACTIVE) &&
                  (cur_data == $past(pix_data[3*SYM_W-1 -: SYM_W]))));

  // R8: a starved boundary resends the previous symbol
  p_starve_repeat_r8: assert property (@(posedge clk) disable iff (rst)
    starve |=> (cur_data == $past(cur_data)));

endmodule

// File: rtl/panel_link_seq.sv
module panel_link_seq
  import link_seq_pkg::*;
#(
  parameter int SYNC_SYMS = 4,
  parameter int CNT_W     = 8,
  parameter int CMD_MAX   = 4,
  parameter int CMD_REQ_W = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     frame_start,
  input  logic                     pix_valid,
  input  logic [3*SYM_W-1:0]       pix_data,
  input  logic [CMD_MAX*SYM_W-1:0] cmd_words,
  input  logic [CNT_W-1:0]         cfg_pre_len,
  input  logic [CMD_REQ_W-1:0]     cfg_cmd_cnt,
  output logic                     data_lane,
  output logic                     clk_lane,
  output logic                     pix_take,
  output logic                     underflow
);

  seq_state_e       state;
  seq_state_e       nxt_state;
  logic [CNT_W-1:0] nxt_cnt;
  logic             load;
  logic             sym_last;
  logic [SYM_W-1:0] nxt_data;
  logic [SYM_W-1:0] nxt_clk;
  logic [SYM_W-1:0] cur_data;
  logic [IDX_W-1:0] bit_idx;
  logic             run;

  assign run = (state != ST_IDLE);

  link_seq_ctrl #(
    .SYNC_SYMS (SYNC_SYMS),
    .CNT_W     (CNT_W),
    .CMD_MAX   (CMD_MAX),
    .CMD_REQ_W (CMD_REQ_W)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .sym_last    (sym_last),
    .cfg_pre_len (cfg_pre_len),
    .cfg_cmd_cnt (cfg_cmd_cnt),
    .state       (state),
    .nxt_state   (nxt_state),
    .nxt_cnt     (nxt_cnt),
    .load        (load)
  );

  link_seq_words #(
    .CMD_MAX (CMD_MAX),
    .CNT_W   (CNT_W)
  ) u_words (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .state     (state),
    .nxt_state (nxt_state),
    .nxt_cnt   (nxt_cnt),
    .pix_valid (pix_valid),
    .pix_data  (pix_data),
    .cmd_words (cmd_words),
    .cur_data  (cur_data),
    .nxt_data  (nxt_data),
    .nxt_clk   (nxt_clk),
    .pix_take  (pix_take),
    .underflow (underflow)
  );

  link_seq_serdes u_serdes (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .run       (run),
    .nxt_data  (nxt_data),
    .nxt_clk   (nxt_clk),
    .data_lane (data_lane),
    .clk_lane  (clk_lane),
    .sym_last  (sym_last),
    .cur_data  (cur_data),
    .bit_idx   (bit_idx)
  );

  // R1: both lanes quiet while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> (!data_lane && !clk_lane && !underflow));

  // R3: normal clock shape outside the sync phase
  p_clk_shape_r3: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_PREAMBLE) || (state == ST_COMMAND) || (state == ST_ACTIVE)) |->
      (clk_lane == (bit_idx < IDX_W'(5))));

  // R4: sync shape on the clock lane, data lane low
  p_sync_shape_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_VSYNC) |->
      ((clk_lane == SYNC_SHAPE[SYM_W-1-int'(bit_idx)]) && !data_lane));

  // R5: alignment pattern on the data lane during preamble
  p_pre_data_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PREAMBLE) |-> (data_lane == (bit_idx < IDX_W'(5))));

endmodule

// File: tb/panel_link_seq_tb.sv
module panel_link_seq_tb;

  localparam logic [9:0] CLK_W  = 10'b1111100000;
  localparam logic [9:0] SYNC_W = 10'b1110001110;
  localparam logic [9:0] PRE_W  = 10'b1111100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_start = 1'b0;
  logic        pix_valid = 1'b1;
  logic [29:0] pix_data;
  logic [39:0] cmd_words;
  logic [7:0]  cfg_pre_len = 8'd2;
  logic [2:0]  cfg_cmd_cnt = 3'd2;
  logic        data_lane, clk_lane, pix_take, underflow;

  int checks = 0;
  int fails = 0;
  int src_idx = 0;
  int exp_idx = 0;

  always #2 clk = ~clk;

  panel_link_seq u_dut (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .pix_valid   (pix_valid),
    .pix_data    (pix_data),
    .cmd_words   (cmd_words),
    .cfg_pre_len (cfg_pre_len),
    .cfg_cmd_cnt (cfg_cmd_cnt),
    .data_lane   (data_lane),
    .clk_lane    (clk_lane),
    .pix_take    (pix_take),
    .underflow   (underflow)
  );

  function automatic logic [9:0] cmd_val(input int i);
    return 10'((i * 181 + 77) % 1024);
  endfunction

  function automatic logic [9:0] pix_val(input int idx, input int k);
    return 10'((idx * 37 + k * 101 + 5) % 1024);
  endfunction

  always @(posedge clk) if (!rst && pix_take) src_idx <= src_idx + 1;

  always_comb pix_data = {pix_val(src_idx, 0), pix_val(src_idx, 1), pix_val(src_idx, 2)};

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Capture one symbol starting at the current negedge; optional frame_start
  // pulse and pix_valid update placed mid-symbol.
  task automatic sym(input logic [9:0] ec, input logic [9:0] ed, input string req,
                     input bit fs, input bit pv);
    logic [9:0] gc, gd;
    for (int i = 0; i < 10; i++) begin
      gc[9-i] = clk_lane;
      gd[9-i] = data_lane;
      if (i == 4) begin
        frame_start = fs;
        pix_valid   = pv;
      end
      if (i == 5) frame_start = 1'b0;
      @(negedge clk);
    end
    check(gc == ec, req, "clock lane symbol", 32'(gc), 32'(ec));
    check(gd == ed, req, "data lane symbol", 32'(gd), 32'(ed));
  endtask

  // R4 sync, R5 preamble, R6 commands; R10 stray frame_start pulses
  task automatic blanking(input int p, input int c);
    int cn;
    cn = (c > 4) ? 4 : c;
    for (int s = 0; s < 4; s++) sym(SYNC_W, 10'd0, "R4", s == 1, 1'b1);
    for (int s = 0; s < p; s++) sym(CLK_W, PRE_W, "R5", s == 0, 1'b1);
    for (int s = 0; s < cn; s++) sym(CLK_W, cmd_val(s), "R6", s == 0, 1'b1);
  endtask

  // R7 one pixel; fs ends the frame after B (R9); starve drops valid for next
  task automatic pixel(input bit fs, input bit starve);
    sym(CLK_W, pix_val(exp_idx, 0), "R7", 1'b0, 1'b1);
    sym(CLK_W, pix_val(exp_idx, 1), "R7", 1'b0, 1'b1);
    sym(CLK_W, pix_val(exp_idx, 2), "R7", fs, !starve);
    exp_idx++;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) cmd_words[i*10 +: 10] = cmd_val(i);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: quiet after reset
    for (int i = 0; i < 6; i++) begin
      check(!data_lane && !clk_lane, "R1", "idle lanes", 32'({data_lane, clk_lane}), 0);
      check(!pix_take && !underflow, "R1", "idle flags", 32'({pix_take, underflow}), 0);
      @(negedge clk);
    end
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    for (int p = 0; p < 3; p++) begin
      for (int ci = 0; ci < 5; ci++) begin
        int c;
        c = (ci == 4) ? 7 : ci;
        cfg_pre_len = 8'(p);
        cfg_cmd_cnt = 3'(c);
        blanking(p, c);
        if (p == 1 && ci == 1) begin
          pixel(1'b0, 1'b1);
          // R8: starved boundary repeats last B word
          sym(CLK_W, pix_val(exp_idx - 1, 2), "R8", 1'b0, 1'b1);
          check(underflow, "R8", "underflow raised", 32'(underflow), 1);
          pixel(1'b1, 1'b0);
        end else if (p == 2 && ci == 3) begin
          pixel(1'b0, 1'b0);
          // R9: frame_start mid-pixel, B symbol dropped
          sym(CLK_W, pix_val(exp_idx, 0), "R9", 1'b0, 1'b1);
          sym(CLK_W, pix_val(exp_idx, 1), "R9", 1'b1, 1'b1);
          exp_idx++;
        end else begin
          pixel(1'b0, 1'b0);
          pixel(1'b1, 1'b0);
        end
      end
    end
    cfg_pre_len = 8'd5;
    cfg_cmd_cnt = 3'd4;
    blanking(5, 4);
    pixel(1'b0, 1'b0);
    check(underflow, "R8", "underflow still set", 32'(underflow), 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule